// File: doc/BRIEF.md
# Page Address Translator with Associative Entry Cache

This block turns a virtual address into a physical address for a processor's memory path. A small fully associative cache of recent page translations sits in front of a single-level page table in memory. Every cached entry is compared with the incoming page number in parallel. On a hit, the response is produced combinationally in the cycle the request is accepted.

On a miss, the block first checks the page number against a table-length input. It then reads one page table entry through a read port, at the table base plus the page number. It checks the entry's valid and write-permission bits, caches the entry if it is valid, and returns the response a few cycles later.

A flush strobe empties the cache when software switches to another page table. Faults are reported as a two-bit code beside the hit/miss flag.

Top module: `vpx_xlate`

## Requirements
- R1: The virtual address splits into a 20-bit page number (bits 31:12) and a 12-bit offset (bits 11:0). A successful response returns `{frame, offset}`.
- R2: When a cached entry matches the page number, `rsp_valid` and `rsp_hit` are 1 in the same cycle as the accepted request, and no table read is issued.
- R3: On a miss, exactly one table read is issued at word address `ptbr + page`. The response follows the read data with `rsp_hit` = 0.
- R4: On a miss whose page number is `>= ptlr`, the response carries fault code 1 and no table read is issued.
- R5: A fetched entry with bit 0 (valid) clear yields fault code 2 and is not cached, so the next access to that page misses again.
- R6: Entry bit 1 set means writable and clear means read-only. A write to a read-only page yields fault code 3, on a hit and on a miss alike, while reads of that page succeed.
- R7: A valid fetched entry (frame in bits 21:2) is cached, and a later access to the same page hits.
- R8: A fill uses the lowest-numbered empty entry. When no entry is empty, it replaces entries round-robin, starting at entry 0 after reset or flush.
- R9: `flush` invalidates every cached entry and resets the replacement pointer, so subsequent accesses miss.
- R10: After reset `req_ready` = 1, `rsp_valid` = 0 and `pt_rd_en` = 0. `req_ready` is 0 while a miss is in progress. `pt_rd_en` is a one-cycle pulse. A faulted response drives `rsp_paddr` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_vaddr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access |
| rsp_valid | output | 1 | Response present (one cycle) |
| rsp_paddr | output | 32 | Physical address, 0 on fault |
| rsp_fault | output | 2 | 0 none, 1 bound, 2 invalid, 3 protection |
| rsp_hit | output | 1 | 1 = served from the entry cache |
| pt_rd_en | output | 1 | Table read strobe |
| pt_rd_addr | output | 32 | Table word address |
| pt_rd_valid | input | 1 | Table read data present |
| pt_rd_data | input | 32 | Table entry: bit0 valid, bit1 writable, bits 21:2 frame |
| ptbr | input | 32 | Table base word address |
| ptlr | input | 21 | Table length in entries |
| flush | input | 1 | Invalidate all cached entries |

## Verification
The bench sweeps pages 0 to 11 with both reads and writes from an empty cache. In that sweep, page numbers divisible by three are read-only and pages congruent to 4 mod 5 are invalid. This separates a protection fault from an invalid fault and a miss from a hit.

A second pass over pages 0 to 15, run twice, overflows the eight entries. The hit pattern then shows whether the victim order matches round-robin or was wrongly chosen. Page numbers past the length input show that bound faults issue no table read.

A flush followed by refills shows both that entries are cleared and that the pointer restarts at entry 0. Each response is compared with a software model of the cache, checking address, fault code, hit flag, read count and read address.

// File: rtl/vpx_pkg.sv
package vpx_pkg;
   typedef enum logic [1:0] {
      FLT_NONE    = 2'd0,
      FLT_BOUND   = 2'd1,
      FLT_INVALID = 2'd2,
      FLT_PROT    = 2'd3
   } vpx_fault_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_READ,
      ST_WAIT,
      ST_RESP
   } vpx_state_e;
endpackage

// File: rtl/vpx_tlb.sv
module vpx_tlb #(
   parameter int ENTRIES = 8,
   parameter int VPN_W   = 20,
   parameter int PFN_W   = 20,
   localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [VPN_W-1:0]   lk_vpn,
   output logic               lk_hit,
   output logic [PFN_W-1:0]   lk_pfn,
   output logic               lk_wr_ok,
   input  logic               fill_en,
   input  logic [VPN_W-1:0]   fill_vpn,
   input  logic [PFN_W-1:0]   fill_pfn,
   input  logic               fill_wr_ok,
   input  logic               flush,
   output logic [ENTRIES-1:0] vld_o
);
   logic [ENTRIES-1:0] vld_q, match, wok_q;
   logic [VPN_W-1:0]   vpn_q [ENTRIES];
   logic [PFN_W-1:0]   pfn_q [ENTRIES];
   logic [IDX_W-1:0]   ptr_q, ptr_nxt, free_idx, victim;
   logic               any_free;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
      assign match[g] = vld_q[g] && (vpn_q[g] == lk_vpn);
   end

   assign lk_hit = |match;
   assign vld_o  = vld_q;

   always_comb begin
      lk_pfn   = '0;
      lk_wr_ok = 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (match[i]) begin
            lk_pfn   = lk_pfn | pfn_q[i];
            lk_wr_ok = lk_wr_ok | wok_q[i];
         end
      end
   end

   always_comb begin
      any_free = 1'b0;
      free_idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (!vld_q[i]) begin
            any_free = 1'b1;
            free_idx = IDX_W'(i);
         end
      end
   end

   if (ENTRIES == 1) begin : g_single
      assign ptr_nxt = '0;
   end else begin : g_multi
      assign ptr_nxt = (ptr_q == IDX_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
   end

   assign victim = any_free ? free_idx : ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
         ptr_q <= '0;
      end else if (flush) begin
         vld_q <= '0;
         ptr_q <= '0;
      end else if (fill_en) begin
         vld_q[victim] <= 1'b1;
         if (!any_free) ptr_q <= ptr_nxt;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_en && !flush) begin
         vpn_q[victim] <= fill_vpn;
         pfn_q[victim] <= fill_pfn;
         wok_q[victim] <= fill_wr_ok;
      end
   end
endmodule

// File: rtl/vpx_walker.sv
module vpx_walker import vpx_pkg::*; #(
   parameter int VPN_W = 20,
   parameter int PFN_W = 20,
   parameter int PT_AW = 32,
   parameter int PTE_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [VPN_W-1:0] st_vpn,
   input  logic             st_write,
   input  logic [PT_AW-1:0] ptbr,
   input  logic [VPN_W:0]   ptlr,
   output logic             busy,
   output logic             pt_rd_en,
   output logic [PT_AW-1:0] pt_rd_addr,
   input  logic             pt_rd_valid,
   input  logic [PTE_W-1:0] pt_rd_data,
   output logic             fill_en,
   output logic [VPN_W-1:0] fill_vpn,
   output logic [PFN_W-1:0] fill_pfn,
   output logic             fill_wr_ok,
   output logic             done,
   output vpx_fault_e       done_fault,
   output logic [PFN_W-1:0] done_pfn
);
   vpx_state_e       st_q;
   logic [VPN_W-1:0] vpn_q;
   logic             wr_q;
   vpx_fault_e       flt_q;
   logic [PFN_W-1:0] pfn_q;
   logic             ent_ok, ent_wr;

   assign ent_ok     = pt_rd_data[0];
   assign ent_wr     = pt_rd_data[1];
   assign busy       = (st_q != ST_IDLE);
   assign pt_rd_en   = (st_q == ST_READ);
   assign pt_rd_addr = ptbr + PT_AW'(vpn_q);
   assign fill_en    = (st_q == ST_WAIT) && pt_rd_valid && ent_ok;
   assign fill_vpn   = vpn_q;
   assign fill_pfn   = pt_rd_data[PFN_W+1:2];
   assign fill_wr_ok = ent_wr;
   assign done       = (st_q == ST_RESP);
   assign done_fault = flt_q;
   assign done_pfn   = pfn_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         vpn_q <= '0;
         wr_q  <= 1'b0;
         flt_q <= FLT_NONE;
         pfn_q <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (start) begin
               vpn_q <= st_vpn;
               wr_q  <= st_write;
               if ({1'b0, st_vpn} >= ptlr) begin
                  flt_q <= FLT_BOUND;
                  st_q  <= ST_RESP;
               end else begin
                  st_q  <= ST_READ;
               end
            end
            ST_READ: st_q <= ST_WAIT;
            ST_WAIT: if (pt_rd_valid) begin
               pfn_q <= pt_rd_data[PFN_W+1:2];
               if (!ent_ok)               flt_q <= FLT_INVALID;
               else if (wr_q && !ent_wr)  flt_q <= FLT_PROT;
               else                       flt_q <= FLT_NONE;
               st_q <= ST_RESP;
            end
            ST_RESP: st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/vpx_xlate.sv
module vpx_xlate import vpx_pkg::*; #(
   parameter int VA_W      = 32,
   parameter int PAGE_BITS = 12,
   parameter int PFN_W     = 20,
   parameter int ENTRIES   = 8,
   parameter int PT_AW     = 32,
   parameter int PTE_W     = 32,
   localparam int VPN_W    = VA_W - PAGE_BITS,
   localparam int PA_W     = PFN_W + PAGE_BITS
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [VA_W-1:0]  req_vaddr,
   input  logic             req_write,
   output logic             rsp_valid,
   output logic [PA_W-1:0]  rsp_paddr,
   output logic [1:0]       rsp_fault,
   output logic             rsp_hit,
   output logic             pt_rd_en,
   output logic [PT_AW-1:0] pt_rd_addr,
   input  logic             pt_rd_valid,
   input  logic [PTE_W-1:0] pt_rd_data,
   input  logic [PT_AW-1:0] ptbr,
   input  logic [VPN_W:0]   ptlr,
   input  logic             flush
);
   if (PAGE_BITS < 1 || PAGE_BITS >= VA_W) begin : g_bad_page
      $error("vpx_xlate: PAGE_BITS out of range");
   end
   if (PFN_W + 2 > PTE_W) begin : g_bad_pte
      $error("vpx_xlate: entry too narrow for frame and flag bits");
   end
   if (VPN_W > PT_AW || ENTRIES < 1) begin : g_bad_geom
      $error("vpx_xlate: bad table address width or entry count");
   end

   logic [VPN_W-1:0]     vpn;
   logic [PAGE_BITS-1:0] off, off_q;
   logic                 lk_hit, lk_wr_ok, busy, accept, start;
   logic [PFN_W-1:0]     lk_pfn, fill_pfn, done_pfn;
   logic [VPN_W-1:0]     fill_vpn;
   logic                 fill_en, fill_wr_ok, done;
   vpx_fault_e           done_fault, hit_fault;
   logic [ENTRIES-1:0]   tlb_vld;

   assign vpn       = req_vaddr[VA_W-1:PAGE_BITS];
   assign off       = req_vaddr[PAGE_BITS-1:0];
   assign req_ready = !busy;
   assign accept    = req_valid && req_ready;
   assign start     = accept && !lk_hit;
   assign hit_fault = (req_write && !lk_wr_ok) ? FLT_PROT : FLT_NONE;

   vpx_tlb #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_tlb (
      .clk, .rst_n,
      .lk_vpn(vpn), .lk_hit, .lk_pfn, .lk_wr_ok,
      .fill_en, .fill_vpn, .fill_pfn, .fill_wr_ok,
      .flush, .vld_o(tlb_vld)
   );

   vpx_walker #(.VPN_W(VPN_W), .PFN_W(PFN_W), .PT_AW(PT_AW), .PTE_W(PTE_W)) u_walk (
      .clk, .rst_n,
      .start, .st_vpn(vpn), .st_write(req_write),
      .ptbr, .ptlr, .busy,
      .pt_rd_en, .pt_rd_addr, .pt_rd_valid, .pt_rd_data,
      .fill_en, .fill_vpn, .fill_pfn, .fill_wr_ok,
      .done, .done_fault, .done_pfn
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     off_q <= '0;
      else if (start) off_q <= off;
   end

   always_comb begin
      rsp_valid = 1'b0;
      rsp_hit   = 1'b0;
      rsp_fault = FLT_NONE;
      rsp_paddr = '0;
      if (accept && lk_hit) begin
         rsp_valid = 1'b1;
         rsp_hit   = 1'b1;
         rsp_fault = hit_fault;
         if (hit_fault == FLT_NONE) rsp_paddr = {lk_pfn, off};
      end else if (done) begin
         rsp_valid = 1'b1;
         rsp_fault = done_fault;
         if (done_fault == FLT_NONE) rsp_paddr = {done_pfn, off_q};
      end
   end
endmodule

// File: rtl/vpx_xlate_chk.sv
module vpx_xlate_chk #(
   parameter int ENTRIES = 8,
   parameter int PA_W    = 32
) (
   input logic               clk,
   input logic               rst_n,
   input logic               req_ready,
   input logic               req_write,
   input logic               pt_rd_en,
   input logic               rsp_valid,
   input logic [1:0]         rsp_fault,
   input logic               rsp_hit,
   input logic [PA_W-1:0]    rsp_paddr,
   input logic               flush,
   input logic [ENTRIES-1:0] tlb_vld
);
   // R10
   rd_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pt_rd_en |-> !req_ready);
   // R10
   rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pt_rd_en |=> !pt_rd_en);
   // R10
   fault_zero_pa_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault != 2'd0) |-> (rsp_paddr == '0));
   // R4
   bound_is_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault == 2'd1) |-> !rsp_hit);
   // R6
   hit_read_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_hit && !req_write) |-> (rsp_fault == 2'd0));
   // R9
   flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> (tlb_vld == '0));
endmodule

bind vpx_xlate vpx_xlate_chk #(.ENTRIES(ENTRIES), .PA_W(PA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .req_write(req_write),
   .pt_rd_en(pt_rd_en), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
   .rsp_hit(rsp_hit), .rsp_paddr(rsp_paddr), .flush(flush), .tlb_vld(tlb_vld)
);

// File: tb/vpx_xlate_bench.sv
module vpx_xlate_bench;
   localparam int PTBR = 32'h100;
   localparam int PTLR = 64;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, flush = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic        req_ready, rsp_valid, rsp_hit, pt_rd_en;
   logic [31:0] rsp_paddr, pt_rd_addr;
   logic [1:0]  rsp_fault;
   logic        pt_rd_valid = 1'b0;
   logic [31:0] pt_rd_data = '0;
   int          rd_cnt = 0;
   logic [31:0] last_addr = '0;
   int          n_chk = 0, n_bad = 0;
   bit          finished = 1'b0;

   int mvpn [8];
   bit mv   [8];
   int mptr;

   always #10 clk = ~clk;

   vpx_xlate u_vpx_xlate (
      .clk, .rst_n, .req_valid, .req_ready, .req_vaddr, .req_write,
      .rsp_valid, .rsp_paddr, .rsp_fault, .rsp_hit,
      .pt_rd_en, .pt_rd_addr, .pt_rd_valid, .pt_rd_data,
      .ptbr(32'(PTBR)), .ptlr(21'(PTLR)), .flush
   );

   function automatic bit pg_ok(int v);  return (v % 5) != 4; endfunction
   function automatic bit pg_wr(int v);  return (v % 3) != 0; endfunction
   function automatic logic [19:0] pg_frame(int v); return 20'(v * 7 + 3); endfunction

   always @(posedge clk) begin
      pt_rd_valid <= pt_rd_en;
      if (pt_rd_en) begin
         int v;
         v = int'(pt_rd_addr) - PTBR;
         rd_cnt    <= rd_cnt + 1;
         last_addr <= pt_rd_addr;
         pt_rd_data <= {10'd0, pg_frame(v), pg_wr(v), pg_ok(v)};
      end
   end

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic model_clear();
      for (int i = 0; i < 8; i++) mv[i] = 1'b0;
      mptr = 0;
   endtask

   task automatic do_flush();
      @(negedge clk); flush = 1'b1;
      @(negedge clk); flush = 1'b0;
      model_clear();
   endtask

   task automatic xlate(int v, int off, bit wr, string tag);
      bit exp_hit, got;
      int exp_flt, exp_rd, rd0, guard, hidx, fidx;
      logic [31:0] exp_pa, g_pa;
      logic [1:0]  g_flt;
      logic        g_hit;
      string freq;
      hidx = -1;
      for (int i = 0; i < 8; i++) if (mv[i] && mvpn[i] == v) hidx = i;
      exp_hit = (hidx >= 0);
      exp_rd  = 0;
      if (exp_hit) exp_flt = (wr && !pg_wr(v)) ? 3 : 0;
      else if (v >= PTLR) exp_flt = 1;
      else begin
         exp_rd = 1;
         if (!pg_ok(v)) exp_flt = 2;
         else begin
            exp_flt = (wr && !pg_wr(v)) ? 3 : 0;
            fidx = -1;
            for (int i = 0; i < 8; i++) if (!mv[i] && fidx < 0) fidx = i;
            if (fidx < 0) begin fidx = mptr; mptr = (mptr + 1) % 8; end
            mv[fidx] = 1'b1; mvpn[fidx] = v;
         end
      end
      exp_pa = (exp_flt != 0) ? 32'd0 : {pg_frame(v), 12'(off)};
      rd0 = rd_cnt;
      got = 1'b0; g_pa = '0; g_flt = '0; g_hit = 1'b0;
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = {v[19:0], off[11:0]}; req_write = wr;
      #1;
      guard = 0;
      while (!req_ready && guard < 100) begin @(negedge clk); #1; guard++; end
      if (rsp_valid) begin got = 1'b1; g_pa = rsp_paddr; g_flt = rsp_fault; g_hit = rsp_hit; end
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      #1;
      if (!got) chk(req_ready == 1'b0, "R10", {tag, " ready during miss"}, req_ready, 0);
      guard = 0;
      while (!got && guard < 100) begin
         if (rsp_valid) begin got = 1'b1; g_pa = rsp_paddr; g_flt = rsp_fault; g_hit = rsp_hit; end
         else begin @(negedge clk); #1; guard++; end
      end
      chk(got, "R3", {tag, " response seen"}, got, 1);
      freq = (exp_flt == 1) ? "R4" : (exp_flt == 2) ? "R5" : (exp_flt == 3) ? "R6" : "R1";
      chk(g_flt == 2'(exp_flt), freq, {tag, " fault"}, g_flt, exp_flt);
      chk(g_pa == exp_pa, freq, {tag, " paddr"}, g_pa, exp_pa);
      chk(g_hit == exp_hit, exp_hit ? "R2 R7" : "R3 R8", {tag, " hit"}, g_hit, exp_hit);
      chk(rd_cnt - rd0 == exp_rd, exp_hit ? "R2" : (exp_flt == 1 ? "R4" : "R3"),
          {tag, " table reads"}, rd_cnt - rd0, exp_rd);
      if (exp_rd == 1)
         chk(last_addr == 32'(PTBR + v), "R3", {tag, " read address"}, last_addr, PTBR + v);
   endtask

   initial begin
      #(20 * 150000);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      model_clear();
      repeat (3) @(negedge clk);
      #1;
      chk(req_ready == 1'b1, "R10", "reset ready", req_ready, 1);
      chk(rsp_valid == 1'b0, "R10", "reset rsp_valid", rsp_valid, 0);
      chk(pt_rd_en == 1'b0, "R10", "reset pt_rd_en", pt_rd_en, 0);
      rst_n = 1'b1;
      // R1 R2 R3 R5 R6 R7: each page read then written, from empty cache
      for (int v = 0; v < 12; v++) begin
         xlate(v, v * 13 + 5, 1'b0, "sweep rd");
         xlate(v, 12'hfff - v, 1'b1, "sweep wr");
      end
      // R4: beyond the table length
      xlate(PTLR, 1, 1'b0, "bound edge");
      xlate(PTLR + 37, 2, 1'b1, "bound far");
      xlate(PTLR - 1, 3, 1'b0, "bound last legal");
      // R9 then R8: overflow the cache twice over
      do_flush();
      for (int r = 0; r < 2; r++)
         for (int v = 0; v < 16; v++) xlate(v, v, r[0], "replace");
      // R9: flush empties and restarts pointer
      do_flush();
      xlate(1, 7, 1'b0, "post flush");
      for (int v = 20; v < 32; v++) xlate(v, v * 3, 1'b0, "refill");
      xlate(1, 8, 1'b0, "after refill");
      xlate(20, 9, 1'b1, "after refill w");
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule